// File: doc/BRIEF.md
# Trap Entry State-Capture Sequencer

When a trap is accepted, this block freezes every pipeline stage by dropping all stage clock enables and forcing the fetch address to location 0. It then brings the stages back one per cycle in a fixed order: output register, left ALU operand, right ALU operand, ALU status, jump condition. In each cycle it copies the value of the stage that is still frozen, just before that stage is released, into a dedicated save register. The handler can then read the whole frozen pipeline from those save registers.

On return, the handler issues a restore request that carries the saved status word and the saved jump condition. The status is loaded back and the jump condition goes to a holding flip-flop, which corresponds to bit 4 of the processor control word. The ALU clock stays off from the restore until the return jump completes. A trap that arrives while a capture sequence is running is remembered and taken as soon as the sequence ends.

Top module: `trap_capture_seq`

## Requirements
- R1: After reset, all five stage enables are high, `busy` and `fetch_zero` are low, and every save register, `status_out` and `ctl_hold` read zero.
- R2: In the cycle after a trap is accepted (trap_req or a pending trap while idle), `stage_en` is 5'b00000, `fetch_zero` is high and `busy` is high.
- R3: `save_oreg` takes the `oreg_val` presented in the first cycle after acceptance, while all enables are low.
- R4: Enables return one per cycle in the order of the `stage_en` bits: bit0 output register, bit1 left operand, bit2 right operand, bit3 ALU, bit4 jump condition. k cycles after the all-low cycle, the low k bits are set.
- R5: `save_left`, `save_right` and `save_status` take `left_val`, `right_val` and `alu_status` in the 2nd, 3rd and 4th cycles after acceptance.
- R6: `save_jcond` takes bit 17 of `proc_status` in the 5th cycle after acceptance.
- R7: `busy` is high for exactly 5 cycles per trap. After that, all enables are high again unless the ALU is held off.
- R8: A trap request that arrives while `busy` is high is held and accepted on the first idle cycle. Its all-low cycle follows directly after the first sequence's release cycle.
- R9: A restore request loads `restore_status` into `status_out` and `restore_jcond` into `ctl_hold`, both visible the next cycle. It also forces `stage_en[3]` low until the cycle after `ret_done`. A restore request wins over `ret_done` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request |
| oreg_val | input | W | Output register value |
| left_val | input | W | Left ALU operand |
| right_val | input | W | Right ALU operand |
| alu_status | input | W | ALU status word |
| proc_status | input | W | Processor status word (jump condition at bit 17) |
| restore_req | input | 1 | Start of return: load restore values |
| restore_status | input | W | Status word to restore |
| restore_jcond | input | 1 | Jump condition to restore |
| ret_done | input | 1 | Return jump completed |
| stage_en | output | 5 | Per-stage clock enables |
| fetch_zero | output | 1 | Force fetch address to 0 |
| busy | output | 1 | Capture sequence in progress |
| save_oreg | output | W | Saved output register |
| save_left | output | W | Saved left operand |
| save_right | output | W | Saved right operand |
| save_status | output | W | Saved ALU status |
| save_jcond | output | 1 | Saved jump condition |
| status_out | output | W | Restored status word |
| ctl_hold | output | 1 | Control-word bit 4 holding flip-flop |

## Verification
Trap acceptance and the end of a return can fall in the same cycle. In that case `ret_done` releases the ALU hold-off while the new sequence pulls every enable low. The bench provokes this by asserting `trap_req` and `ret_done` together after a restore. It then checks that `stage_en[3]` stays low through the new sequence and comes back exactly at its sequence step. A second collision is a trap arriving while busy, in the last phase or earlier. The bench judges it by the exact cycle in which the second all-low pattern appears.

// File: rtl/trap_capture_seq.sv
module trap_capture_seq #(
  parameter int W      = 32,
  parameter int JC_BIT = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trap_req,
  input  logic [W-1:0] oreg_val,
  input  logic [W-1:0] left_val,
  input  logic [W-1:0] right_val,
  input  logic [W-1:0] alu_status,
  input  logic [W-1:0] proc_status,
  input  logic         restore_req,
  input  logic [W-1:0] restore_status,
  input  logic         restore_jcond,
  input  logic         ret_done,
  output logic [4:0]   stage_en,
  output logic         fetch_zero,
  output logic         busy,
  output logic [W-1:0] save_oreg,
  output logic [W-1:0] save_left,
  output logic [W-1:0] save_right,
  output logic [W-1:0] save_status,
  output logic         save_jcond,
  output logic [W-1:0] status_out,
  output logic         ctl_hold
);

  localparam int NSTG  = 5;
  localparam int ALU_S = 3;

  logic            active, pend, alu_off;
  logic [2:0]      ph;
  logic [NSTG-1:0] rel_mask;

  wire accept = !active && (trap_req || pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      pend        <= 1'b0;
      ph          <= '0;
      save_oreg   <= '0;
      save_left   <= '0;
      save_right  <= '0;
      save_status <= '0;
      save_jcond  <= 1'b0;
    end else begin
      if (accept) begin
        active <= 1'b1;
        ph     <= '0;
      end else if (active) begin
        case (ph)
          3'd0:    save_oreg   <= oreg_val;
          3'd1:    save_left   <= left_val;
          3'd2:    save_right  <= right_val;
          3'd3:    save_status <= alu_status;
          default: save_jcond  <= proc_status[JC_BIT];
        endcase
        ph <= ph + 3'd1;
        if (ph == 3'd4) active <= 1'b0;
      end
      if (accept)                  pend <= 1'b0;
      else if (active && trap_req) pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_out <= '0;
      ctl_hold   <= 1'b0;
      alu_off    <= 1'b0;
    end else if (restore_req) begin
      status_out <= restore_status;
      ctl_hold   <= restore_jcond;
      alu_off    <= 1'b1;
    end else if (ret_done) begin
      alu_off <= 1'b0;
    end
  end

  for (genvar i = 0; i < NSTG; i++) begin : g_rel
    assign rel_mask[i] = !active || (ph > 3'(i));
  end

  assign stage_en   = rel_mask & ~(NSTG'(alu_off) << ALU_S);
  assign fetch_zero = active && (ph == 3'd0);
  assign busy       = active;

  assert_accept_freezes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (trap_req || pend)) |=> (stage_en == '0 && fetch_zero && busy));

  assert_one_per_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($countones(rel_mask) == $countones($past(rel_mask)) + 1));

  assert_oreg_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fetch_zero) |=> (save_oreg == $past(oreg_val)));

  assert_jcond_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph == 3'd4) |=> (save_jcond == $past(proc_status[JC_BIT]) && !busy));

  assert_trap_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trap_req) |=> (pend || busy));

  assert_restore_alu_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |=> (!stage_en[ALU_S] && status_out == $past(restore_status)));

endmodule

// File: tb/trap_capture_seq_bench.sv
`timescale 1ns/1ps
module trap_capture_seq_bench;
  localparam int W = 32;

  logic clk = 0, rst_n = 0;
  logic trap_req = 0, restore_req = 0, restore_jcond = 0, ret_done = 0;
  logic [W-1:0] oreg_val = 0, left_val = 0, right_val = 0, alu_status = 0, proc_status = 0;
  logic [W-1:0] restore_status = 0;
  logic [4:0] stage_en;
  logic fetch_zero, busy, save_jcond, ctl_hold;
  logic [W-1:0] save_oreg, save_left, save_right, save_status, status_out;

  trap_capture_seq #(.W(W), .JC_BIT(17)) u_trap_capture_seq (
    .clk, .rst_n, .trap_req, .oreg_val, .left_val, .right_val, .alu_status, .proc_status,
    .restore_req, .restore_status, .restore_jcond, .ret_done,
    .stage_en, .fetch_zero, .busy, .save_oreg, .save_left, .save_right, .save_status,
    .save_jcond, .status_out, .ctl_hold);

  always #2.5 clk = ~clk;

  typedef struct {
    int stamp; string req;
    logic [4:0] en; logic bsy; logic fz;
    bit chk_save; logic [W-1:0] so, sl, sr, ss; logic sj;
    bit chk_rst; logic [W-1:0] st; logic hold;
  } item_t;

  item_t q[$];
  int cyc = 0, total = 0, bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic cmp(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", req, what, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    while (q.size() > 0 && q[0].stamp <= cyc) begin
      item_t it;
      it = q.pop_front();
      cmp(it.req, "stage_en", W'(stage_en), W'(it.en));
      cmp(it.req, "busy", W'(busy), W'(it.bsy));
      cmp(it.req, "fetch_zero", W'(fetch_zero), W'(it.fz));
      if (it.chk_save) begin
        cmp(it.req, "save_oreg", save_oreg, it.so);
        cmp(it.req, "save_left", save_left, it.sl);
        cmp(it.req, "save_right", save_right, it.sr);
        cmp(it.req, "save_status", save_status, it.ss);
        cmp(it.req, "save_jcond", W'(save_jcond), W'(it.sj));
      end
      if (it.chk_rst) begin
        cmp(it.req, "status_out", status_out, it.st);
        cmp(it.req, "ctl_hold", W'(ctl_hold), W'(it.hold));
      end
    end
  end

  function automatic item_t mk(int stamp, string req, logic [4:0] en, logic bsy, logic fz);
    item_t it;
    it = '{stamp: stamp, req: req, en: en, bsy: bsy, fz: fz, chk_save: 0,
           so: 0, sl: 0, sr: 0, ss: 0, sj: 0, chk_rst: 0, st: 0, hold: 0};
    return it;
  endfunction

  // trap seen at cycle n; accepted at the edge into n+1
  task automatic drive_capture(int n, logic [W-1:0] base, bit jb, bit rearm, bit aoff);
    logic [4:0] m;
    item_t it;
    m = aoff ? 5'b10111 : 5'b11111;
    q.push_back(mk(n + 1, "R2", 5'b00000, 1, 1));
    for (int k = 1; k <= 4; k++)
      q.push_back(mk(n + k + 1, "R4", 5'((1 << k) - 1) & m, 1, 0));
    it = mk(n + 6, "R3 R5 R6 R7", m, 0, 0);
    it.chk_save = 1;
    it.so = base + 1; it.sl = base + 2 + 32'h100; it.sr = base + 3 + 32'h200;
    it.ss = base + 4 + 32'h300; it.sj = jb;
    q.push_back(it);
    for (int k = 1; k <= 5; k++) begin
      while (cyc != n + k) @(negedge clk);
      if (k == 1) trap_req = 0;
      if (rearm && k == 2) trap_req = 1;
      if (rearm && k == 3) trap_req = 0;
      if (k == 1) ret_done = 0;
      oreg_val    = base + k;
      left_val    = base + k + 32'h100;
      right_val   = base + k + 32'h200;
      alu_status  = base + k + 32'h300;
      proc_status = (base + k) & ~(32'h1 << 17);
      if ((k == 5) == jb) proc_status[17] = 1'b1;
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    item_t it;
    repeat (3) @(negedge clk);
    rst_n = 1;
    it = mk(cyc + 1, "R1", 5'b11111, 0, 0);
    it.chk_save = 1; it.chk_rst = 1;
    q.push_back(it);
    repeat (3) @(negedge clk);

    // basic capture, jump condition bit set
    trap_req = 1; n = cyc;
    drive_capture(n, 32'hA000_0000, 1, 0, 0);
    repeat (3) @(negedge clk);

    // trap while busy: held, taken right after (R8)
    trap_req = 1; n = cyc;
    drive_capture(n, 32'h5000_0010, 0, 1, 0);
    q.push_back(mk(n + 7, "R8", 5'b00000, 1, 1));
    drive_capture(n + 6, 32'h0C00_0020, 1, 0, 0);
    repeat (3) @(negedge clk);

    // restore loads status and hold bit, ALU held off (R9)
    restore_req = 1; restore_status = 32'hDEAD_BEEF; restore_jcond = 1; n = cyc;
    it = mk(n + 1, "R9", 5'b10111, 0, 0);
    it.chk_rst = 1; it.st = 32'hDEAD_BEEF; it.hold = 1;
    q.push_back(it);
    q.push_back(mk(n + 2, "R9", 5'b10111, 0, 0));
    @(negedge clk); restore_req = 0;
    @(negedge clk);

    // trap while ALU held off: bit3 stays low after sequence (R9 R7)
    trap_req = 1; n = cyc;
    drive_capture(n, 32'h1234_0000, 0, 0, 1);
    q.push_back(mk(n + 7, "R9", 5'b10111, 0, 0));
    @(negedge clk);
    @(negedge clk);

    // restore wins over ret_done in same cycle (R9)
    restore_req = 1; ret_done = 1; restore_status = 32'h0000_0055; restore_jcond = 0; n = cyc;
    it = mk(n + 1, "R9", 5'b10111, 0, 0);
    it.chk_rst = 1; it.st = 32'h0000_0055; it.hold = 0;
    q.push_back(it);
    @(negedge clk); restore_req = 0; ret_done = 0;

    // collision: ret_done and trap in same cycle (R9 R2 R4)
    trap_req = 1; ret_done = 1; n = cyc;
    drive_capture(n, 32'h7700_0000, 1, 0, 0);
    q.push_back(mk(n + 7, "R7", 5'b11111, 0, 0));
    repeat (4) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule